// File: doc/BRIEF.md
# PLL Clock Mode Controller

This controller runs in the VCO clock domain and decides how the system clock is formed. It produces a PLL clock enable that pulses once every (post-divider + 1) VCO cycles, and a bus clock enable that pulses on every second PLL enable. It also decides whether the PLL is engaged with the internal reference or with the external oscillator. After reset it always starts in the internal-reference mode. It moves to the external-reference mode only when software has set the oscillator-enable bit and both the synchronized PLL lock and the oscillator-up status are high. It moves back when software clears that bit.

Oscillator-up status depends on lock: whenever the synchronized lock is low, oscillator-up reads low. In external mode, a low oscillator-up switches the PLL enable to a fixed divide-by-four, whatever the post-divider holds. Both the fallback and every other change of ratio or mode wait for the divider's terminal count, so no enable period is ever cut short.

Each of the two status bits has a sticky change flag. Writing one to a flag clears it. The interrupt request is the OR of the flags that are enabled. The block also resolves the watchdog/tick clock-source request. The external-oscillator choice is granted only in external mode.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the mode output is 0 (internal reference), both flags and the interrupt are 0, and the divider ratio is RST_POSTDIV+1 (4 with defaults).
- R2: pll_ce is high for one cycle in every (post_div+1) cycles of the VCO clock.
- R3: bus_ce is high only together with pll_ce, on every second pll_ce pulse, so the bus rate is half the PLL rate.
- R4: lock_raw and osc_rdy_raw pass through a two-flop synchronizer. A change on the raw input shows on status after the second rising edge.
- R5: status[0] is the synchronized lock. status[1] (oscillator up) is the synchronized oscillator-ready ANDed with the synchronized lock, so it is 0 whenever lock is 0.
- R6: mode becomes 1 (external reference) only at a divider terminal count where osc_en is 1 and status is 2'b11.
- R7: In external mode, while status[1] is 0, the divider ratio is 4 whatever post_div holds.
- R8: A new ratio (from post_div, from a mode change, or entering or leaving the fallback) is loaded only at a terminal count. Every pll_ce interval equals the ratio loaded at the previous pulse.
- R9: flags[0] is set on any change of status[0], and flags[1] on any change of status[1]. A flag stays set until a write with flag_clr_we=1 and a 1 in its bit of flag_clr_data. A change in the same cycle wins over the clear.
- R10: irq is 1 exactly when some bit of flags AND irq_en is 1.
- R11: With mode 1, clearing osc_en returns mode to 0 at the next terminal count. The mode changes only at a terminal count.
- R12: tick_src follows tick_sel, with 0 = internal reference, 1 = RC oscillator and 2 = external oscillator. A request of 2 in internal mode, or a request of 3, yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock, the controller's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw | input | 1 | Unsynchronized PLL lock indication |
| osc_rdy_raw | input | 1 | Unsynchronized oscillator-ready indication |
| osc_en | input | 1 | Oscillator-enable register bit |
| post_div | input | PDIV_W | Post-divider register value |
| flag_clr_we | input | 1 | Write strobe for the flag clear |
| flag_clr_data | input | 2 | Write-one-to-clear mask (bit 0 lock flag, bit 1 oscillator flag) |
| irq_en | input | 2 | Per-flag interrupt enables |
| tick_sel | input | 2 | Requested watchdog/tick clock source |
| pll_ce | output | 1 | PLL clock enable pulse |
| bus_ce | output | 1 | Bus clock enable pulse |
| mode | output | 1 | 0 internal-reference engaged, 1 external-reference engaged |
| status | output | 2 | {oscillator up, lock}, synchronized |
| flags | output | 2 | Sticky change flags {oscillator, lock} |
| irq | output | 1 | Status interrupt request |
| tick_src | output | 2 | Granted watchdog/tick clock source |

## Verification
The divider is tried with post-divider values 3, 1, 0 and 5. This separates an off-by-one in the ratio and a wrong bus halving from a correct count. It also shows that the divide-by-one case still makes bus pulses. Lock and oscillator-ready are raised one at a time. This shows the two-cycle synchronizer delay, and shows that external mode needs the enable bit as well as both status bits. In external mode, dropping oscillator-ready with a post-divider of 1 gives a pulse rate that only the forced divide-by-four can produce. Dropping lock while oscillator-ready stays high shows the oscillator status being forced low.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic {
      MODE_INT = 1'b0,
      MODE_EXT = 1'b1
   } clk_mode_e;

   typedef enum logic [1:0] {
      TSRC_IREF = 2'd0,
      TSRC_RC   = 2'd1,
      TSRC_XOSC = 2'd2
   } tick_src_e;

   localparam int NFLAGS         = 2;
   localparam int FLAG_LOCK      = 0;
   localparam int FLAG_OSC       = 1;
   localparam int FALLBACK_RATIO = 4;
endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   initial begin
      if (STAGES < 2) $error("clkmode_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_in;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
   parameter int RW        = 5,
   parameter int RST_RATIO = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] ratio_next,
   output logic          tc,
   output logic          bus_tick
);
   initial begin
      if (RST_RATIO < 1 || RST_RATIO >= (1 << RW))
         $error("clkmode_div: RST_RATIO out of range");
   end

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] ratio_q;
   logic          half_q;

   assign tc       = (cnt_q == ratio_q - RW'(1));
   assign bus_tick = tc & half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= RW'(RST_RATIO);
         half_q  <= 1'b0;
      end else if (tc) begin
         cnt_q   <= '0;
         ratio_q <= ratio_next;
         half_q  <= ~half_q;
      end else begin
         cnt_q   <= cnt_q + RW'(1);
      end
   end
endmodule

// File: rtl/clkmode_flags.sv
module clkmode_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status_in,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] prev_q;

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            flag_q    <= 1'b0;
         end else begin
            prev_q[g] <= status_in[g];
            if (status_in[g] != prev_q[g]) flag_q <= 1'b1;
            else if (clr_we && clr_mask[g]) flag_q <= 1'b0;
         end
      end
      assign flags_o[g] = flag_q;
   end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int PDIV_W      = 4,
   parameter int RST_POSTDIV = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_vco,
   input  logic              rst_n,
   input  logic              lock_raw,
   input  logic              osc_rdy_raw,
   input  logic              osc_en,
   input  logic [PDIV_W-1:0] post_div,
   input  logic              flag_clr_we,
   input  logic [1:0]        flag_clr_data,
   input  logic [1:0]        irq_en,
   input  logic [1:0]        tick_sel,
   output logic              pll_ce,
   output logic              bus_ce,
   output logic              mode,
   output logic [1:0]        status,
   output logic [1:0]        flags,
   output logic              irq,
   output logic [1:0]        tick_src
);
   localparam int RW = PDIV_W + 1;

   initial begin
      if (PDIV_W < 2) $error("clkmode_ctrl: PDIV_W must be at least 2");
      if (RST_POSTDIV >= (1 << PDIV_W)) $error("clkmode_ctrl: RST_POSTDIV too wide");
   end

   logic [1:0]    sync_q;
   logic          lock_s;
   logic          osc_up;
   logic          tc;
   logic          bus_tick;
   clk_mode_e     mode_q;
   clk_mode_e     mode_d;
   logic [RW-1:0] ratio_nx;

   clkmode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_vco),
      .rst_n (rst_n),
      .d_in  ({osc_rdy_raw, lock_raw}),
      .d_out (sync_q)
   );

   assign lock_s = sync_q[0];
   assign osc_up = sync_q[1] & lock_s;

   always_comb begin
      mode_d = mode_q;
      if (mode_q == MODE_INT && osc_en && lock_s && osc_up) mode_d = MODE_EXT;
      else if (mode_q == MODE_EXT && !osc_en) mode_d = MODE_INT;
   end

   always_comb begin
      if (mode_d == MODE_EXT && !osc_up) ratio_nx = RW'(FALLBACK_RATIO);
      else ratio_nx = {1'b0, post_div} + RW'(1);
   end

   always_ff @(posedge clk_vco or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_INT;
      else if (tc) mode_q <= mode_d;
   end

   clkmode_div #(.RW(RW), .RST_RATIO(RST_POSTDIV + 1)) u_div (
      .clk        (clk_vco),
      .rst_n      (rst_n),
      .ratio_next (ratio_nx),
      .tc         (tc),
      .bus_tick   (bus_tick)
   );

   clkmode_flags #(.N(NFLAGS)) u_flags (
      .clk       (clk_vco),
      .rst_n     (rst_n),
      .status_in ({osc_up, lock_s}),
      .clr_we    (flag_clr_we),
      .clr_mask  (flag_clr_data),
      .flags_o   (flags)
   );

   always_comb begin
      unique case (tick_sel)
         TSRC_RC:   tick_src = TSRC_RC;
         TSRC_XOSC: tick_src = (mode_q == MODE_EXT) ? TSRC_XOSC : TSRC_IREF;
         default:   tick_src = TSRC_IREF;
      endcase
   end

   assign pll_ce = tc;
   assign bus_ce = bus_tick;
   assign mode   = mode_q;
   assign status = {osc_up, lock_s};
   assign irq    = |(flags & irq_en);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
   input logic       clk_vco,
   input logic       rst_n,
   input logic       osc_en,
   input logic       flag_clr_we,
   input logic [1:0] flag_clr_data,
   input logic [1:0] irq_en,
   input logic       pll_ce,
   input logic       bus_ce,
   input logic       mode,
   input logic [1:0] status,
   input logic [1:0] flags,
   input logic       irq,
   input logic [1:0] tick_src
);
   AST_BUS_WITH_PLL: assert property (@(posedge clk_vco) disable iff (!rst_n)
      bus_ce |-> pll_ce); // R3
   AST_OSC_NEEDS_LOCK: assert property (@(posedge clk_vco) disable iff (!rst_n)
      !status[0] |-> !status[1]); // R5
   AST_EXT_ENTRY_COND: assert property (@(posedge clk_vco) disable iff (!rst_n)
      $rose(mode) |-> $past(osc_en && status == 2'b11)); // R6
   AST_MODE_AT_BOUNDARY: assert property (@(posedge clk_vco) disable iff (!rst_n)
      !pll_ce |=> $stable(mode)); // R11
   AST_FLAG_STICKY_LOCK: assert property (@(posedge clk_vco) disable iff (!rst_n)
      (flags[0] && !(flag_clr_we && flag_clr_data[0])) |=> flags[0]); // R9
   AST_FLAG_STICKY_OSC: assert property (@(posedge clk_vco) disable iff (!rst_n)
      (flags[1] && !(flag_clr_we && flag_clr_data[1])) |=> flags[1]); // R9
   AST_IRQ_QUIET: assert property (@(posedge clk_vco) disable iff (!rst_n)
      ((flags & irq_en) == 2'b00) |-> !irq); // R10
   AST_NO_XOSC_INTERNAL: assert property (@(posedge clk_vco) disable iff (!rst_n)
      !mode |-> (tick_src != 2'd2)); // R12
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
   .clk_vco       (clk_vco),
   .rst_n         (rst_n),
   .osc_en        (osc_en),
   .flag_clr_we   (flag_clr_we),
   .flag_clr_data (flag_clr_data),
   .irq_en        (irq_en),
   .pll_ce        (pll_ce),
   .bus_ce        (bus_ce),
   .mode          (mode),
   .status        (status),
   .flags         (flags),
   .irq           (irq),
   .tick_src      (tick_src)
);

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
   localparam int PW = 4;

   logic          clk_vco = 1'b0;
   logic          rst_n = 1'b0;
   logic          lock_raw = 1'b0, osc_rdy_raw = 1'b0, osc_en = 1'b0;
   logic [PW-1:0] post_div = 4'd3;
   logic          flag_clr_we = 1'b0;
   logic [1:0]    flag_clr_data = 2'b00, irq_en = 2'b00, tick_sel = 2'b00;
   logic          pll_ce, bus_ce, mode, irq;
   logic [1:0]    status, flags, tick_src;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #10 clk_vco = ~clk_vco;

   clkmode_ctrl #(.PDIV_W(PW), .RST_POSTDIV(3), .SYNC_STAGES(2)) dut (
      .clk_vco(clk_vco), .rst_n(rst_n), .lock_raw(lock_raw), .osc_rdy_raw(osc_rdy_raw),
      .osc_en(osc_en), .post_div(post_div), .flag_clr_we(flag_clr_we),
      .flag_clr_data(flag_clr_data), .irq_en(irq_en), .tick_sel(tick_sel),
      .pll_ce(pll_ce), .bus_ce(bus_ce), .mode(mode), .status(status),
      .flags(flags), .irq(irq), .tick_src(tick_src)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int l1, l2, o1, o2, pl, po, fl0, fl1, md, cnt, rat, half;

   always @(posedge clk_vco) begin
      if (!rst_n) begin
         l1 = 0; l2 = 0; o1 = 0; o2 = 0; pl = 0; po = 0;
         fl0 = 0; fl1 = 0; md = 0; cnt = 0; rat = 4; half = 0;
      end else begin
         int up, tc;
         up = (l2 != 0 && o2 != 0) ? 1 : 0;
         tc = (cnt == rat - 1) ? 1 : 0;
         fl0 = ((fl0 != 0 && !(flag_clr_we && flag_clr_data[0])) || l2 != pl) ? 1 : 0;
         fl1 = ((fl1 != 0 && !(flag_clr_we && flag_clr_data[1])) || up != po) ? 1 : 0;
         pl = l2; po = up;
         if (tc != 0) begin
            if (md == 0 && osc_en && l2 != 0 && up != 0) md = 1;
            else if (md == 1 && !osc_en) md = 0;
            rat = (md == 1 && up == 0) ? 4 : int'(post_div) + 1;
            half = 1 - half;
            cnt = 0;
         end else cnt++;
         l2 = l1; l1 = int'(lock_raw);
         o2 = o1; o1 = int'(osc_rdy_raw);
      end
   end

   always @(negedge clk_vco) begin
      if (rst_n && !done) begin
         int epc, ebc, eup, eirq, etk;
         epc = (cnt == rat - 1) ? 1 : 0;
         ebc = (epc != 0 && half != 0) ? 1 : 0;
         eup = (l2 != 0 && o2 != 0) ? 1 : 0;
         eirq = ((fl0 != 0 && irq_en[0]) || (fl1 != 0 && irq_en[1])) ? 1 : 0;
         etk = (tick_sel == 2'd1) ? 1 : (tick_sel == 2'd2 && md == 1) ? 2 : 0;
         chk(int'(pll_ce) == epc, "R8 pll_ce vs model", int'(pll_ce), epc);
         chk(int'(bus_ce) == ebc, "R3 bus_ce vs model", int'(bus_ce), ebc);
         chk(int'(mode) == md, "R6/R11 mode vs model", int'(mode), md);
         chk(int'(status) == eup * 2 + l2, "R5 status vs model", int'(status), eup * 2 + l2);
         chk(int'(flags) == fl1 * 2 + fl0, "R9 flags vs model", int'(flags), fl1 * 2 + fl0);
         chk(int'(irq) == eirq, "R10 irq vs model", int'(irq), eirq);
         chk(int'(tick_src) == etk, "R12 tick_src vs model", int'(tick_src), etk);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk_vco);
      #1;
   endtask

   task automatic count(input int n, output int pc, output int bc);
      pc = 0; bc = 0;
      repeat (n) begin
         @(negedge clk_vco);
         pc += int'(pll_ce);
         bc += int'(bus_ce);
      end
      @(posedge clk_vco);
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk_vco);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int pc, bc;
      step(5);
      rst_n = 1'b1;
      @(negedge clk_vco);
      chk(mode == 1'b0, "R1 reset mode", int'(mode), 0);
      chk(flags == 2'b00 && irq == 1'b0, "R1 reset flags/irq", int'({flags, irq}), 0);
      step(1);
      count(40, pc, bc);
      chk(pc == 10, "R1 R2 reset ratio 4", pc, 10);
      chk(bc == 5, "R3 bus half rate", bc, 5);

      post_div = 4'd1; step(8); count(40, pc, bc);
      chk(pc == 20 && bc == 10, "R2 ratio 2", pc, 20);
      post_div = 4'd0; step(4); count(40, pc, bc);
      chk(pc == 40 && bc == 20, "R2 ratio 1", pc, 40);
      post_div = 4'd5; step(8); count(48, pc, bc);
      chk(pc == 8 && bc == 4, "R2 ratio 6", pc, 8);
      post_div = 4'd3; step(8);

      tick_sel = 2'd2; step(1);
      chk(tick_src == 2'd0, "R12 xosc refused in internal", int'(tick_src), 0);
      tick_sel = 2'd1; step(1);
      chk(tick_src == 2'd1, "R12 rc granted", int'(tick_src), 1);

      lock_raw = 1'b1;
      @(posedge clk_vco); @(negedge clk_vco);
      chk(status[0] == 1'b0, "R4 one edge not enough", int'(status[0]), 0);
      @(negedge clk_vco);
      chk(status[0] == 1'b1, "R4 seen after two edges", int'(status[0]), 1);
      osc_rdy_raw = 1'b1; step(20);
      chk(mode == 1'b0, "R6 no entry without osc_en", int'(mode), 0);
      chk(status == 2'b11, "R5 both up", int'(status), 3);
      chk(flags == 2'b11, "R9 flags set on change", int'(flags), 3);
      chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
      irq_en = 2'b01; step(1);
      chk(irq == 1'b1, "R10 irq enabled", int'(irq), 1);
      flag_clr_we = 1'b1; flag_clr_data = 2'b10; step(1);
      flag_clr_we = 1'b0;
      chk(flags == 2'b01, "R9 clear one flag", int'(flags), 1);
      flag_clr_we = 1'b1; flag_clr_data = 2'b01; step(1);
      flag_clr_we = 1'b0; flag_clr_data = 2'b00;
      chk(flags == 2'b00 && irq == 1'b0, "R9 R10 all cleared", int'(flags), 0);

      osc_en = 1'b1; step(20);
      chk(mode == 1'b1, "R6 external entered", int'(mode), 1);
      tick_sel = 2'd2; step(1);
      chk(tick_src == 2'd2, "R12 xosc granted", int'(tick_src), 2);
      post_div = 4'd1; step(8);

      osc_rdy_raw = 1'b0; step(20);
      count(40, pc, bc);
      chk(pc == 10, "R7 fallback divide by four", pc, 10);
      chk(mode == 1'b1, "R7 stays external", int'(mode), 1);
      chk(flags[1] == 1'b1, "R9 osc flag on loss", int'(flags[1]), 1);
      osc_rdy_raw = 1'b1; step(20);
      count(40, pc, bc);
      chk(pc == 20, "R7 fallback left", pc, 20);

      lock_raw = 1'b0; step(4);
      chk(status == 2'b00, "R5 osc forced low on lock loss", int'(status), 0);
      lock_raw = 1'b1; step(20);

      osc_en = 1'b0; step(20);
      chk(mode == 1'b0, "R11 back to internal", int'(mode), 0);
      chk(tick_src == 2'd0, "R12 xosc withdrawn", int'(tick_src), 0);

      step(4);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule